// File: doc/BRIEF.md
# DDR Command Spacing Monitor

This block sits beside a DDR memory command bus and watches the command issued in each clock cycle: READ, WRITE, PRECHARGE or nothing. Each command carries a bank number, an auto-precharge flag and a burst-chop flag. The block also takes the programmed read latency, write latency and precharge recovery time. It measures how far each command lands from the earlier commands that constrain it. When a command arrives too early, it records the first such violation as an error code. The code stays until software-side logic pulses the clear input.

Read and write spacing is tracked once for the whole device. Precharge recovery is tracked separately for each bank. The minimum gap from a READ to a WRITE is derived from the programmed latencies (read latency plus the column-to-column gap plus two, minus write latency) and is not a fixed constant. Burst chop never relaxes a gap. The block also reports which banks currently hold an open row. An access opens a row. An explicit PRECHARGE closes it. An access with auto-precharge closes it on its own once the burst has finished.

Top module: `cmdspc_mon`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, err_flag is 0, err_code is 0 and bank_open is all zeros.
- R2: Command encoding on cmd_op is 0 = idle, 1 = READ, 2 = WRITE, 3 = PRECHARGE. A READ issued fewer than CCD cycles after the previous READ (any bank) is violation code 1. Every READ, legal or not, restarts this spacing.
- R3: A WRITE issued fewer than L cycles after the last READ is violation code 2. Here L = rd_lat + CCD + 2 - wr_lat, or L = 1 when that value is below 1.
- R4: A READ or WRITE issued fewer than CCD cycles after the last WRITE is violation code 4 (write burst interrupted). Codes 1 and 2 take precedence over code 4 on the same command.
- R5: A PRECHARGE to bank b issued fewer than pre_rec cycles after the last READ to bank b is violation code 3. A READ to a different bank imposes nothing.
- R6: The cycle after a violation, err_flag is 1 and err_code shows its code. While err_flag is set and err_clr is low, later violations leave err_code unchanged.
- R7: err_clr returns err_flag and err_code to 0 on the next cycle. If a violation occurs in the same cycle as the clear, that violation is latched instead.
- R8: A READ or WRITE without auto-precharge to bank b sets bank_open bit b in the next cycle. A PRECHARGE to bank b clears it in the next cycle and cancels any pending automatic close.
- R9: A READ or WRITE with cmd_ap = 1 to bank b sets bank_open bit b in the next cycle. The bit reads 0 from cycle lat + BURST_CK + 1 after the command, with lat = rd_lat for a READ and wr_lat for a WRITE. A later access to that bank before then replaces the pending close.
- R10: cmd_chop has no effect. Every spacing and every automatic close time is the same as for a full-length burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 2 | Command this cycle: 0 idle, 1 READ, 2 WRITE, 3 PRECHARGE |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| cmd_ap | input | 1 | Auto-precharge requested with a READ or WRITE |
| cmd_chop | input | 1 | Burst-chop flag (does not affect any timing) |
| rd_lat | input | LAT_W | Programmed read latency in cycles |
| wr_lat | input | LAT_W | Programmed write latency in cycles |
| pre_rec | input | LAT_W | Minimum cycles from READ to PRECHARGE of the same bank |
| err_clr | input | 1 | Clears the latched error |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 3 | Code of the first latched violation, 0 when clear |
| bank_open | output | BANKS | One bit per bank, 1 while that bank holds an open row |

## Verification
The bound checker checks the following every cycle: the error flag holds and the code stays frozen until a clear; the code is zero whenever the flag is low and always within the defined set; back-to-back READs are caught; and an access or a PRECHARGE updates the addressed bank's open bit on the next cycle. Other properties need a record of earlier traffic, and only the bench scenarios can show them. These are the latency-derived READ-to-WRITE gap and its clamp, per-bank precharge recovery, the precedence between codes, and a violation captured in the same cycle as a clear. They also include the exact cycle at which an auto-precharge access drops its open bit, and the fact that burst chop changes nothing.

// File: rtl/cmdspc_pkg.sv
package cmdspc_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2,
      OP_PRE  = 2'd3
   } cmd_op_e;

   typedef enum logic [2:0] {
      ERR_NONE  = 3'd0,
      ERR_RDRD  = 3'd1,
      ERR_RDWR  = 3'd2,
      ERR_PRE   = 3'd3,
      ERR_WRINT = 3'd4
   } err_code_e;

   localparam int CODE_W = 3;

endpackage

// File: rtl/cmdspc_dev_timer.sv
// Device-wide spacing: cycles since the last READ and since the last WRITE,
// compared against the column gap and the latency-derived read-to-write gap.
module cmdspc_dev_timer #(
   parameter int LAT_W     = 5,
   parameter int CNT_W     = 7,
   parameter int CCD       = 4,
   parameter int LIMIT_REG = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_go,
   input  logic             wr_go,
   input  logic [LAT_W-1:0] rd_lat,
   input  logic [LAT_W-1:0] wr_lat,
   output logic             rr_hit,
   output logic             rw_hit,
   output logic             wi_hit
);

   localparam logic [CNT_W-1:0] SAT   = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] CCD_V = CNT_W'(CCD);
   localparam logic [CNT_W-1:0] GAP_V = CNT_W'(CCD + 2);

   generate
      if (CCD < 1) begin : g_bad_ccd
         $error("cmdspc_dev_timer: CCD must be at least 1");
      end
      if ((1 << LAT_W) + CCD + 2 >= (1 << CNT_W)) begin : g_bad_cnt
         $error("cmdspc_dev_timer: CNT_W too narrow for the latency range");
      end
   endgenerate

   logic [CNT_W-1:0] since_rd;
   logic [CNT_W-1:0] since_wr;
   logic [CNT_W-1:0] rl_e;
   logic [CNT_W-1:0] wl_e;
   logic [CNT_W-1:0] up_sum;
   logic [CNT_W-1:0] lim_raw;
   logic [CNT_W-1:0] rw_lim;

   assign rl_e    = CNT_W'(rd_lat);
   assign wl_e    = CNT_W'(wr_lat);
   assign up_sum  = rl_e + GAP_V;
   assign lim_raw = (up_sum > wl_e) ? (up_sum - wl_e) : ONE;

   generate
      if (LIMIT_REG != 0) begin : g_lim_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rw_lim <= SAT;
            end else begin
               rw_lim <= lim_raw;
            end
         end
      end else begin : g_lim_comb
         assign rw_lim = lim_raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rd <= SAT;
         since_wr <= SAT;
      end else begin
         if (rd_go) begin
            since_rd <= ONE;
         end else if (since_rd != SAT) begin
            since_rd <= since_rd + ONE;
         end
         if (wr_go) begin
            since_wr <= ONE;
         end else if (since_wr != SAT) begin
            since_wr <= since_wr + ONE;
         end
      end
   end

   assign rr_hit = rd_go && (since_rd < CCD_V);
   assign rw_hit = wr_go && (since_rd < rw_lim);
   assign wi_hit = (rd_go || wr_go) && (since_wr < CCD_V);

endmodule

// File: rtl/cmdspc_bank_trk.sv
// Per-bank state: precharge recovery countdown after a READ, open-row bit,
// and the automatic close countdown of an auto-precharge access.
module cmdspc_bank_trk #(
   parameter int BANKS    = 8,
   parameter int BANK_W   = 3,
   parameter int LAT_W    = 5,
   parameter int BURST_CK = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_go,
   input  logic              wr_go,
   input  logic              pre_go,
   input  logic              ap,
   input  logic [BANK_W-1:0] bank,
   input  logic [LAT_W-1:0]  rd_lat,
   input  logic [LAT_W-1:0]  wr_lat,
   input  logic [LAT_W-1:0]  pre_rec,
   output logic              pre_hit,
   output logic [BANKS-1:0]  open_o
);

   localparam int              AP_W  = LAT_W + 1;
   localparam logic [AP_W-1:0] BCK_V = AP_W'(BURST_CK);
   localparam logic [AP_W-1:0] AP_1  = AP_W'(1);
   localparam logic [LAT_W-1:0] LAT_1 = LAT_W'(1);

   generate
      if (BURST_CK < 1 || BURST_CK >= (1 << LAT_W)) begin : g_bad_burst
         $error("cmdspc_bank_trk: BURST_CK out of range");
      end
      if (BANKS > (1 << BANK_W)) begin : g_bad_banks
         $error("cmdspc_bank_trk: BANK_W too narrow for BANKS");
      end
   endgenerate

   logic             acc_go;
   logic [AP_W-1:0]  close_len;
   logic [LAT_W-1:0] pre_load;
   logic [BANKS-1:0] pre_hits;

   assign acc_go    = rd_go || wr_go;
   assign close_len = (rd_go ? AP_W'(rd_lat) : AP_W'(wr_lat)) + BCK_V;
   assign pre_load  = (pre_rec != '0) ? (pre_rec - LAT_1) : '0;

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         logic             sel;
         logic [LAT_W-1:0] pre_cnt;
         logic [AP_W-1:0]  ap_cnt;
         logic             open_q;

         assign sel = (bank == BANK_W'(b));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_cnt <= '0;
            end else if (rd_go && sel) begin
               pre_cnt <= pre_load;
            end else if (pre_cnt != '0) begin
               pre_cnt <= pre_cnt - LAT_1;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               open_q <= 1'b0;
               ap_cnt <= '0;
            end else if (acc_go && sel) begin
               open_q <= 1'b1;
               ap_cnt <= ap ? close_len : '0;
            end else if (pre_go && sel) begin
               open_q <= 1'b0;
               ap_cnt <= '0;
            end else if (ap_cnt != '0) begin
               ap_cnt <= ap_cnt - AP_1;
               if (ap_cnt == AP_1) begin
                  open_q <= 1'b0;
               end
            end
         end

         assign pre_hits[b] = pre_go && sel && (pre_cnt != '0);
         assign open_o[b]   = open_q;
      end
   endgenerate

   assign pre_hit = |pre_hits;

endmodule

// File: rtl/cmdspc_err_latch.sv
// First-error capture with clear; a violation coinciding with a clear wins.
module cmdspc_err_latch #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              hit,
   input  logic [CODE_W-1:0] code_in,
   output logic              flag,
   output logic [CODE_W-1:0] code
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         code <= '0;
      end else if (clr) begin
         flag <= hit;
         code <= hit ? code_in : '0;
      end else if (!flag && hit) begin
         flag <= 1'b1;
         code <= code_in;
      end
   end

endmodule

// File: rtl/cmdspc_mon.sv
module cmdspc_mon
   import cmdspc_pkg::*;
#(
   parameter int BANKS     = 8,
   parameter int BANK_W    = (BANKS > 1) ? $clog2(BANKS) : 1,
   parameter int LAT_W     = 5,
   parameter int CNT_W     = 7,
   parameter int CCD       = 4,
   parameter int BURST_CK  = 4,
   parameter int LIMIT_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd_op,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic              cmd_ap,
   input  logic              cmd_chop,
   input  logic [LAT_W-1:0]  rd_lat,
   input  logic [LAT_W-1:0]  wr_lat,
   input  logic [LAT_W-1:0]  pre_rec,
   input  logic              err_clr,
   output logic              err_flag,
   output logic [2:0]        err_code,
   output logic [BANKS-1:0]  bank_open
);

   generate
      if (BANKS < 1) begin : g_bad_banks
         $error("cmdspc_mon: BANKS must be at least 1");
      end
   endgenerate

   cmd_op_e           op;
   logic              rd_go;
   logic              wr_go;
   logic              pre_go;
   logic              rr_hit;
   logic              rw_hit;
   logic              wi_hit;
   logic              pre_hit;
   logic              any_hit;
   logic [CODE_W-1:0] code_sel;
   logic              unused_chop;

   // Burst chop never shortens a gap, so the flag is deliberately dropped.
   assign unused_chop = cmd_chop;

   assign op     = cmd_op_e'(cmd_op);
   assign rd_go  = (op == OP_RD);
   assign wr_go  = (op == OP_WR);
   assign pre_go = (op == OP_PRE);

   cmdspc_dev_timer #(
      .LAT_W     (LAT_W),
      .CNT_W     (CNT_W),
      .CCD       (CCD),
      .LIMIT_REG (LIMIT_REG)
   ) dev_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_go  (rd_go),
      .wr_go  (wr_go),
      .rd_lat (rd_lat),
      .wr_lat (wr_lat),
      .rr_hit (rr_hit),
      .rw_hit (rw_hit),
      .wi_hit (wi_hit)
   );

   cmdspc_bank_trk #(
      .BANKS    (BANKS),
      .BANK_W   (BANK_W),
      .LAT_W    (LAT_W),
      .BURST_CK (BURST_CK)
   ) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_go   (rd_go),
      .wr_go   (wr_go),
      .pre_go  (pre_go),
      .ap      (cmd_ap),
      .bank    (cmd_bank),
      .rd_lat  (rd_lat),
      .wr_lat  (wr_lat),
      .pre_rec (pre_rec),
      .pre_hit (pre_hit),
      .open_o  (bank_open)
   );

   // Lower code wins when one command breaks two rules.
   always_comb begin
      if (rr_hit) begin
         code_sel = ERR_RDRD;
      end else if (rw_hit) begin
         code_sel = ERR_RDWR;
      end else if (pre_hit) begin
         code_sel = ERR_PRE;
      end else if (wi_hit) begin
         code_sel = ERR_WRINT;
      end else begin
         code_sel = ERR_NONE;
      end
   end

   assign any_hit = rr_hit || rw_hit || pre_hit || wi_hit;

   cmdspc_err_latch #(
      .CODE_W (CODE_W)
   ) err_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (err_clr),
      .hit     (any_hit),
      .code_in (code_sel),
      .flag    (err_flag),
      .code    (err_code)
   );

endmodule

// File: rtl/cmdspc_chk.sv
module cmdspc_chk #(
   parameter int BANKS  = 8,
   parameter int BANK_W = 3,
   parameter int CCD    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cmd_op,
   input logic [BANK_W-1:0] cmd_bank,
   input logic              cmd_ap,
   input logic              err_clr,
   input logic              err_flag,
   input logic [2:0]        err_code,
   input logic [BANKS-1:0]  bank_open
);

   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag);

   // R6
   code_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> $stable(err_code));

   // R1 R7
   code_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !err_flag |-> (err_code == 3'd0));

   // R6
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_code <= 3'd4);

   // R8
   pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 2'd3) |=> !bank_open[$past(cmd_bank)]);

   // R8 R9
   acc_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 2'd1 || cmd_op == 2'd2) |=> bank_open[$past(cmd_bank)]);

   // R9
   ap_flag_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ap && cmd_op == 2'd1) |=> bank_open[$past(cmd_bank)]);

   generate
      if (CCD > 1) begin : g_b2b
         // R2
         rd_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_op == 2'd1 && $past(cmd_op) == 2'd1 && (!err_flag || err_clr))
            |=> (err_flag && err_code == 3'd1));
      end
   endgenerate

endmodule

bind cmdspc_mon cmdspc_chk #(
   .BANKS  (BANKS),
   .BANK_W (BANK_W),
   .CCD    (CCD)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_op    (cmd_op),
   .cmd_bank  (cmd_bank),
   .cmd_ap    (cmd_ap),
   .err_clr   (err_clr),
   .err_flag  (err_flag),
   .err_code  (err_code),
   .bank_open (bank_open)
);

// File: tb/cmdspc_mon_tb_top.sv
`timescale 1ns/1ps
module cmdspc_mon_tb_top;

   localparam int BANKS = 8;
   localparam int CCD   = 4;
   localparam int BCK   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [2:0] cmd_bank = 3'd0;
   logic       cmd_ap = 1'b0;
   logic       cmd_chop = 1'b0;
   logic [4:0] rd_lat = 5'd0;
   logic [4:0] wr_lat = 5'd0;
   logic [4:0] pre_rec = 5'd0;
   logic       err_clr = 1'b0;
   logic       err_flag;
   logic [2:0] err_code;
   logic [7:0] bank_open;

   always #10 clk = ~clk;

   cmdspc_mon #(.BANKS(BANKS), .CCD(CCD), .BURST_CK(BCK)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
      .cmd_ap(cmd_ap), .cmd_chop(cmd_chop), .rd_lat(rd_lat), .wr_lat(wr_lat),
      .pre_rec(pre_rec), .err_clr(err_clr), .err_flag(err_flag),
      .err_code(err_code), .bank_open(bank_open)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int rl, wl, pr;
   int last_rd = -1000;
   int last_wr = -1000;
   int last_rd_b [BANKS];
   bit open_m [BANKS];
   int close_at [BANKS];
   bit flag_m = 1'b0;
   int code_m = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int exp_code(input int op, input int bank);
      int rwlim;
      rwlim = rl + CCD + 2 - wl;
      if (rwlim < 1) rwlim = 1;
      if (op == 1) begin
         if (cyc - last_rd < CCD) return 1;
         if (cyc - last_wr < CCD) return 4;
      end else if (op == 2) begin
         if (cyc - last_rd < rwlim) return 2;
         if (cyc - last_wr < CCD) return 4;
      end else if (op == 3) begin
         if (cyc - last_rd_b[bank] < pr) return 3;
      end
      return 0;
   endfunction

   function automatic string tag_for(input int v);
      case (v)
         1: return "R2";
         2: return "R3";
         3: return "R5";
         4: return "R4";
         default: return "R6";
      endcase
   endfunction

   task automatic set_cfg(input int r, input int w, input int p);
      rl = r; wl = w; pr = p;
      rd_lat = r[4:0]; wr_lat = w[4:0]; pre_rec = p[4:0];
   endtask

   // One cycle: drive at the falling edge, update the model, check after the next rising edge.
   task automatic step(input int op, input int bank, input bit ap, input bit chop,
                       input bit clr, input string tag);
      int v;
      logic [7:0] expv;
      string et;
      for (int b = 0; b < BANKS; b++) begin
         if (close_at[b] >= 0 && cyc >= close_at[b]) begin
            open_m[b] = 1'b0;
            close_at[b] = -1;
         end
      end
      v = exp_code(op, bank);
      cmd_op = op[1:0]; cmd_bank = bank[2:0]; cmd_ap = ap; cmd_chop = chop; err_clr = clr;
      if (clr) begin
         flag_m = (v != 0);
         code_m = v;
      end else if (!flag_m && v != 0) begin
         flag_m = 1'b1;
         code_m = v;
      end
      if (op == 1) begin last_rd = cyc; last_rd_b[bank] = cyc; end
      if (op == 2) last_wr = cyc;
      if (op == 1 || op == 2) begin
         open_m[bank] = 1'b1;
         close_at[bank] = ap ? cyc + ((op == 1) ? rl : wl) + BCK + 1 : -1;
      end else if (op == 3) begin
         open_m[bank] = 1'b0;
         close_at[bank] = -1;
      end
      @(posedge clk);
      @(negedge clk);
      for (int b = 0; b < BANKS; b++)
         expv[b] = open_m[b] && !(close_at[b] >= 0 && cyc + 1 >= close_at[b]);
      et = (tag != "") ? tag : tag_for(v);
      chk(err_flag == flag_m, et, "err_flag", int'(err_flag), int'(flag_m));
      chk(err_code == code_m[2:0], et, "err_code", int'(err_code), code_m);
      chk(bank_open == expv, (tag != "") ? tag : "R8/R9", "bank_open",
          int'(bank_open), int'(expv));
      cyc++;
   endtask

   task automatic idle(input int n, input bit clr, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 1'b0, 1'b0, clr, tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5eed_c0de));
      for (int b = 0; b < BANKS; b++) begin
         last_rd_b[b] = -1000; open_m[b] = 1'b0; close_at[b] = -1;
      end
      set_cfg(11, 8, 6);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs during reset
      chk(err_flag == 1'b0, "R1", "err_flag", int'(err_flag), 0);
      chk(err_code == 3'd0, "R1", "err_code", int'(err_code), 0);
      chk(bank_open == 8'd0, "R1", "bank_open", int'(bank_open), 0);
      rst_n = 1'b1;
      idle(2, 1'b0, "R1");

      // R2: READ three cycles after a READ
      step(1, 0, 0, 0, 0, "R2");
      idle(2, 0, "R2");
      step(1, 1, 0, 0, 0, "R2");
      idle(1, 1, "R7");
      // R10: chop keeps the full gap; legal at CCD, illegal below it
      step(1, 2, 0, 1, 0, "R10");
      idle(3, 0, "R10");
      step(1, 2, 0, 1, 0, "R10");
      idle(2, 0, "R10");
      step(1, 3, 0, 1, 0, "R10");
      idle(1, 1, "R7");

      // R3: READ to WRITE needs 11+4+2-8 = 9 cycles
      idle(20, 0, "");
      step(1, 2, 0, 0, 0, "R3");
      idle(7, 0, "R3");
      step(2, 3, 0, 0, 0, "R3");
      idle(1, 1, "R7");
      step(1, 2, 0, 0, 0, "R3");
      idle(8, 0, "R3");
      step(2, 3, 0, 0, 0, "R3");

      // R4: READ two cycles after a WRITE, reads long past
      idle(40, 0, "");
      step(2, 4, 0, 0, 0, "R4");
      idle(1, 0, "R4");
      step(1, 5, 0, 0, 0, "R4");
      idle(1, 1, "R7");

      // R5: precharge recovery is per bank
      idle(20, 0, "");
      step(1, 1, 0, 0, 0, "R5");
      idle(2, 0, "R5");
      step(3, 2, 0, 0, 0, "R5");
      step(3, 1, 0, 0, 0, "R5");
      // R6: a later READ-READ violation does not replace code 3
      step(1, 6, 0, 0, 0, "R6");
      step(1, 6, 0, 0, 0, "R6");
      // R7: clear together with a violation captures the new one
      step(1, 6, 0, 0, 1, "R7");
      idle(1, 1, "R7");

      // R8: open on access, closed by PRECHARGE
      idle(20, 0, "");
      step(2, 3, 0, 0, 0, "R8");
      idle(6, 0, "R8");
      step(3, 3, 0, 0, 0, "R8");
      // R9: auto-precharge WRITE and READ close by themselves
      idle(10, 0, "");
      step(2, 6, 1, 0, 0, "R9");
      idle(16, 0, "R9");
      step(1, 7, 1, 1, 0, "R9");
      idle(20, 0, "R9");

      // Random phases, one latency setting each
      for (int ph = 0; ph < 4; ph++) begin
         idle(70, 1, "");
         case (ph)
            0: set_cfg(11, 8, 6);
            1: set_cfg(5, 9, 3);
            2: set_cfg(7, 20, 0);
            default: set_cfg(20, 5, 15);
         endcase
         idle(2, 1, "");
         for (int i = 0; i < 400; i++) begin
            int r, op;
            r = int'($urandom_range(99));
            op = (r < 50) ? 0 : (r < 70) ? 1 : (r < 85) ? 2 : 3;
            step(op, int'($urandom_range(7)), ($urandom_range(9) < 3),
                 $urandom_range(1) == 1, ($urandom_range(19) == 0), "");
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule